// File: doc/BRIEF.md
# Accumulator CPU Core

A multicycle processor core with one 24-bit accumulator and a 20-bit word address space. Beside the accumulator it holds a program counter, a return link register, a stack pointer and a frame pointer. It reaches a single synchronous memory port for both instruction fetch and data. The port has an address, write data and a write enable, and read data returns on the cycle after the address is presented. The core fetches one word, decodes it, and spends one or two further cycles on operand or pointer accesses before it fetches again.

An instruction word carries a 4-bit major opcode in bits 23..20 and a 20-bit address or constant in bits 19..0. Major opcode 0xF opens an extended space whose 8-bit code is bits 23..16. A halt instruction parks the core with a status output raised. The memory array itself sits outside the block.

Top module: `acc_core`

## Requirements
- R1: With rst_ni low, halted_o and mem_we_o are 0 and every register is zero. The first cycle after release presents address 0 for fetch.
- R2: Each instruction starts with a fetch cycle that drives the program counter on mem_addr_o and increments the counter modulo 2^20. A decode cycle follows, then an execute cycle. Operand reads add one cycle, and double-indirect reads add two.
- R3: Major 0x0 loads bits 19..0 into the accumulator with bits 23..20 cleared. Major 0x1 loads memory word a. Major 0x2 writes the accumulator to word a during the execute cycle.
- R4: Major 0x3 adds memory word a modulo 2^24. Majors 0x4, 0x5 and 0x6 apply bitwise AND, OR and XOR with word a.
- R5: Major 0x7 sets the accumulator to 0xFFFFFF when it equals memory word a, and to 0 otherwise.
- R6: Major 0x8 jumps to a. Major 0x9 jumps to a only when accumulator bit 23 is 1, and otherwise falls through.
- R7: Major 0xC stores the incremented program counter, zero-extended, in the link register and jumps to a. Extended 0xF3 loads the program counter from the link register's low 20 bits.
- R8: Major 0xA reads word a, uses its low 20 bits as an address, and loads the word there. Major 0xB reads word a the same way and writes the accumulator to the address it holds. The upper 4 bits of the pointer word are ignored.
- R9: Majors 0xD and 0xE read and write the word at stack pointer plus a, modulo 2^20.
- R10: Extended 0xF1 inverts every accumulator bit. Extended 0xF2 rotates the accumulator right by one, with bit 0 entering bit 23.
- R11: Extended 0xF4/0xF5 copy link to and from the accumulator, 0xF6/0xF7 do the same for the stack pointer, and 0xF8/0xF9 for the frame pointer. Each copy moves all 24 bits.
- R12: Extended 0xFA adds bits 15..0, sign-extended to 24 bits, to the accumulator modulo 2^24.
- R13: Extended 0xF0 raises halted_o from the cycle after its execute cycle. After that no further write occurs and halted_o stays high until reset. Extended codes 0xFB..0xFF change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 20 | Word address for fetch, read or write |
| mem_we_o | output | 1 | Write strobe for this cycle |
| mem_wdata_o | output | 24 | Write data (accumulator) |
| mem_rdata_i | input | 24 | Read data for the address of the previous cycle |
| halted_o | output | 1 | Core has executed a halt |

## Verification
The hardest cases to reach are those where a stored value drives later control flow. Examples are a return whose target was written by a call several instructions earlier, and a stack-relative access whose sum crosses the top of the address space. The most awkward is a double-indirect access whose pointer word carries junk in its upper bits. Small programs are placed in the bench memory to set each of these up on purpose. A behavioural instruction-level model of the same programs predicts every bus cycle, which is compared against the port each clock. Final memory contents are then compared as well, so a wrong register value shows up wherever it is later stored.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam int DATA_W = 24;
  localparam int ADDR_W = 20;
  localparam int OPC_W  = 4;
  localparam int XOP_W  = 8;
  localparam int SIMM_W = 16;

  typedef enum logic [2:0] {
    S_FETCH, S_LATCH, S_EXEC, S_PTR, S_OPND, S_HALT
  } state_e;

  typedef enum logic [4:0] {
    K_NOP, K_LDI, K_RD, K_WR, K_JMP, K_JMPN, K_CALL, K_IRD, K_IWR,
    K_SRD, K_SWR, K_HALT, K_NOT, K_ROR, K_RET, K_GRA, K_PRA, K_GSP,
    K_PSP, K_GFP, K_PFP, K_ADDI
  } kind_e;

  typedef enum logic [2:0] {
    A_PASS, A_ADD, A_AND, A_OR, A_XOR, A_EQ
  } alu_e;

  typedef struct packed {
    kind_e kind;
    alu_e  alu;
  } dec_t;
endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
  import acc_core_pkg::*;
(
  input  logic [XOP_W-1:0] op_i,
  output dec_t             dec_o
);
  logic [OPC_W-1:0] major;
  assign major = op_i[XOP_W-1 -: OPC_W];

  always_comb begin
    dec_o.kind = K_NOP;
    dec_o.alu  = A_PASS;
    case (major)
      4'h0: dec_o.kind = K_LDI;
      4'h1: dec_o.kind = K_RD;
      4'h2: dec_o.kind = K_WR;
      4'h3: begin dec_o.kind = K_RD; dec_o.alu = A_ADD; end
      4'h4: begin dec_o.kind = K_RD; dec_o.alu = A_AND; end
      4'h5: begin dec_o.kind = K_RD; dec_o.alu = A_OR;  end
      4'h6: begin dec_o.kind = K_RD; dec_o.alu = A_XOR; end
      4'h7: begin dec_o.kind = K_RD; dec_o.alu = A_EQ;  end
      4'h8: dec_o.kind = K_JMP;
      4'h9: dec_o.kind = K_JMPN;
      4'hA: dec_o.kind = K_IRD;
      4'hB: dec_o.kind = K_IWR;
      4'hC: dec_o.kind = K_CALL;
      4'hD: dec_o.kind = K_SRD;
      4'hE: dec_o.kind = K_SWR;
      default: begin
        case (op_i)
          8'hF0: dec_o.kind = K_HALT;
          8'hF1: dec_o.kind = K_NOT;
          8'hF2: dec_o.kind = K_ROR;
          8'hF3: dec_o.kind = K_RET;
          8'hF4: dec_o.kind = K_GRA;
          8'hF5: dec_o.kind = K_PRA;
          8'hF6: dec_o.kind = K_GSP;
          8'hF7: dec_o.kind = K_PSP;
          8'hF8: dec_o.kind = K_GFP;
          8'hF9: dec_o.kind = K_PFP;
          8'hFA: dec_o.kind = K_ADDI;
          default: dec_o.kind = K_NOP;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
  import acc_core_pkg::*;
(
  input  alu_e              op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    case (op_i)
      A_ADD:   res_o = acc_i + opnd_i;
      A_AND:   res_o = acc_i & opnd_i;
      A_OR:    res_o = acc_i | opnd_i;
      A_XOR:   res_o = acc_i ^ opnd_i;
      A_EQ:    res_o = (acc_i == opnd_i) ? '1 : '0;
      default: res_o = opnd_i;
    endcase
  end
endmodule

// File: rtl/acc_core_agu.sv
module acc_core_agu
  import acc_core_pkg::*;
(
  input  state_e            state_i,
  input  kind_e             kind_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o
);
  always_comb begin
    addr_o = pc_i;
    we_o   = 1'b0;
    case (state_i)
      S_EXEC: begin
        case (kind_i)
          K_RD, K_IRD, K_IWR: addr_o = imm_i;
          K_WR:  begin addr_o = imm_i; we_o = 1'b1; end
          K_SRD: addr_o = sp_i + imm_i;
          K_SWR: begin addr_o = sp_i + imm_i; we_o = 1'b1; end
          default: ;
        endcase
      end
      S_PTR: begin
        addr_o = ptr_i;
        we_o   = (kind_i == K_IWR);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halted_o
);
  localparam int SEXT_W = DATA_W - SIMM_W;

  state_e            state_q;
  logic [DATA_W-1:0] ir_q, acc_q, ra_q, sp_q, fp_q;
  logic [ADDR_W-1:0] pc_q, imm;
  logic [DATA_W-1:0] simm, alu_res;
  dec_t              dec;
  kind_e             kind;

  assign imm  = ir_q[ADDR_W-1:0];
  assign simm = {{SEXT_W{ir_q[SIMM_W-1]}}, ir_q[SIMM_W-1:0]};
  assign kind = dec.kind;

  acc_core_decode u_dec (
    .op_i  (ir_q[DATA_W-1 -: XOP_W]),
    .dec_o (dec)
  );

  acc_core_alu u_alu (
    .op_i   (dec.alu),
    .acc_i  (acc_q),
    .opnd_i (mem_rdata_i),
    .res_o  (alu_res)
  );

  acc_core_agu u_agu (
    .state_i (state_q),
    .kind_i  (kind),
    .pc_i    (pc_q),
    .imm_i   (imm),
    .sp_i    (sp_q[ADDR_W-1:0]),
    .ptr_i   (mem_rdata_i[ADDR_W-1:0]),
    .addr_o  (mem_addr_o),
    .we_o    (mem_we_o)
  );

  assign mem_wdata_o = acc_q;
  assign halted_o    = (state_q == S_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      ir_q    <= '0;
      pc_q    <= '0;
      acc_q   <= '0;
      ra_q    <= '0;
      sp_q    <= '0;
      fp_q    <= '0;
    end else begin
      case (state_q)
        S_FETCH: begin
          pc_q    <= pc_q + 1'b1;
          state_q <= S_LATCH;
        end
        S_LATCH: begin
          ir_q    <= mem_rdata_i;
          state_q <= S_EXEC;
        end
        S_EXEC: begin
          state_q <= S_FETCH;
          case (kind)
            K_LDI:  acc_q <= DATA_W'(imm);
            K_RD, K_SRD:  state_q <= S_OPND;
            K_IRD, K_IWR: state_q <= S_PTR;
            K_JMP:  pc_q <= imm;
            K_JMPN: if (acc_q[DATA_W-1]) pc_q <= imm;
            K_CALL: begin ra_q <= DATA_W'(pc_q); pc_q <= imm; end
            K_RET:  pc_q <= ra_q[ADDR_W-1:0];
            K_HALT: state_q <= S_HALT;
            K_NOT:  acc_q <= ~acc_q;
            K_ROR:  acc_q <= {acc_q[0], acc_q[DATA_W-1:1]};
            K_GRA:  acc_q <= ra_q;
            K_PRA:  ra_q  <= acc_q;
            K_GSP:  acc_q <= sp_q;
            K_PSP:  sp_q  <= acc_q;
            K_GFP:  acc_q <= fp_q;
            K_PFP:  fp_q  <= acc_q;
            K_ADDI: acc_q <= acc_q + simm;
            default: ;
          endcase
        end
        S_PTR:  state_q <= (kind == K_IRD) ? S_OPND : S_FETCH;
        S_OPND: begin
          acc_q   <= alu_res;
          state_q <= S_FETCH;
        end
        default: state_q <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_core_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halted_i,
  input logic              we_i,
  input state_e            state_i,
  input kind_e             kind_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] ra_i
);
  logic in_exec;
  assign in_exec = (state_i == S_EXEC);

  assert_halt_sticky_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i);

  assert_halt_no_write_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> !we_i);

  assert_fetch_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_FETCH) |=> pc_i == ADDR_W'($past(pc_i) + 1'b1));

  assert_const_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exec && kind_i == K_LDI) |=> acc_i[DATA_W-1 -: OPC_W] == '0);

  assert_branch_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exec && kind_i == K_JMPN && !acc_i[DATA_W-1]) |=> $stable(pc_i));

  assert_call_link_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exec && kind_i == K_CALL) |=> ra_i == DATA_W'($past(pc_i)));

  assert_return_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exec && kind_i == K_RET) |=> pc_i == $past(ra_i[ADDR_W-1:0]));

  assert_rotate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exec && kind_i == K_ROR) |=> acc_i == {$past(acc_i[0]), $past(acc_i[DATA_W-1:1])});
endmodule

bind acc_core acc_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .halted_i (halted_o),
  .we_i     (mem_we_o),
  .state_i  (state_q),
  .kind_i   (kind),
  .pc_i     (pc_q),
  .acc_i    (acc_q),
  .ra_i     (ra_q)
);

// File: tb/acc_core_tb.sv
`timescale 1ns/1ps
module acc_core_tb;
  localparam int AM = 'hFFFFF;
  localparam int DM = 'hFFFFFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] mem_addr_o;
  logic        mem_we_o;
  logic [23:0] mem_wdata_o;
  logic [23:0] mem_rdata_i = '0;
  logic        halted_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  acc_core u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .halted_o    (halted_o)
  );

  // bench-owned memory, one-cycle read latency
  int dmem [int];
  int mmem [int];

  function automatic int drd(int a);
    return dmem.exists(a) ? dmem[a] : 0;
  endfunction
  function automatic int mrd(int a);
    return mmem.exists(a) ? mmem[a] : 0;
  endfunction

  always @(posedge clk_i) begin
    mem_rdata_i <= 24'(drd(int'(mem_addr_o)));
    if (mem_we_o) dmem[int'(mem_addr_o)] = int'(mem_wdata_o);
  end

  // expected bus trace
  bit    q_ca[$];
  int    q_ad[$];
  bit    q_we[$];
  int    q_wd[$];
  bit    q_h[$];
  string q_rq[$];

  task automatic push(bit ca, int ad, bit we, int wd, bit h, string rq);
    q_ca.push_back(ca); q_ad.push_back(ad); q_we.push_back(we);
    q_wd.push_back(wd); q_h.push_back(h); q_rq.push_back(rq);
  endtask

  function automatic int ins(int op, int a);
    return (op << 20) | (a & AM);
  endfunction
  function automatic int ext(int x, int s);
    return (x << 16) | (s & 'hFFFF);
  endfunction

  task automatic run_model();
    int pc = 0, acc = 0, ra = 0, sp = 0, fp = 0;
    int ir, op, a, v, p, s, x;
    bit done = 0;
    q_ca.delete(); q_ad.delete(); q_we.delete();
    q_wd.delete(); q_h.delete(); q_rq.delete();
    for (int n = 0; n < 1000 && !done; n++) begin
      push(1, pc, 0, 0, 0, "R2");
      ir = mrd(pc);
      pc = (pc + 1) & AM;
      push(0, 0, 0, 0, 0, "R2");
      op = (ir >> 20) & 15;
      a  = ir & AM;
      case (op)
        0: begin push(0, 0, 0, 0, 0, "R3"); acc = a; end
        1, 3, 4, 5, 6, 7: begin
          push(1, a, 0, 0, 0, op == 7 ? "R5" : (op == 1 ? "R3" : "R4"));
          push(0, 0, 0, 0, 0, op == 7 ? "R5" : (op == 1 ? "R3" : "R4"));
          v = mrd(a);
          case (op)
            1: acc = v;
            3: acc = (acc + v) & DM;
            4: acc = acc & v;
            5: acc = acc | v;
            6: acc = acc ^ v;
            default: acc = (acc == v) ? DM : 0;
          endcase
        end
        2: begin push(1, a, 1, acc, 0, "R3"); mmem[a] = acc; end
        8: begin push(0, 0, 0, 0, 0, "R6"); pc = a; end
        9: begin push(0, 0, 0, 0, 0, "R6"); if ((acc & 'h800000) != 0) pc = a; end
        10: begin
          push(1, a, 0, 0, 0, "R8");
          p = mrd(a) & AM;
          push(1, p, 0, 0, 0, "R8");
          push(0, 0, 0, 0, 0, "R8");
          acc = mrd(p);
        end
        11: begin
          push(1, a, 0, 0, 0, "R8");
          p = mrd(a) & AM;
          push(1, p, 1, acc, 0, "R8");
          mmem[p] = acc;
        end
        12: begin push(0, 0, 0, 0, 0, "R7"); ra = pc; pc = a; end
        13: begin
          p = (sp + a) & AM;
          push(1, p, 0, 0, 0, "R9");
          push(0, 0, 0, 0, 0, "R9");
          acc = mrd(p);
        end
        14: begin
          p = (sp + a) & AM;
          push(1, p, 1, acc, 0, "R9");
          mmem[p] = acc;
        end
        default: begin
          x = (ir >> 16) & 255;
          case (x)
            'hF0: begin
              push(0, 0, 0, 0, 0, "R13");
              for (int k = 0; k < 5; k++) push(0, 0, 0, 0, 1, "R13");
              done = 1;
            end
            'hF1: begin push(0, 0, 0, 0, 0, "R10"); acc = ~acc & DM; end
            'hF2: begin push(0, 0, 0, 0, 0, "R10"); acc = (acc >> 1) | ((acc & 1) << 23); end
            'hF3: begin push(0, 0, 0, 0, 0, "R7"); pc = ra & AM; end
            'hF4: begin push(0, 0, 0, 0, 0, "R11"); acc = ra; end
            'hF5: begin push(0, 0, 0, 0, 0, "R11"); ra = acc; end
            'hF6: begin push(0, 0, 0, 0, 0, "R11"); acc = sp; end
            'hF7: begin push(0, 0, 0, 0, 0, "R11"); sp = acc; end
            'hF8: begin push(0, 0, 0, 0, 0, "R11"); acc = fp; end
            'hF9: begin push(0, 0, 0, 0, 0, "R11"); fp = acc; end
            'hFA: begin
              push(0, 0, 0, 0, 0, "R12");
              s = ir & 'hFFFF;
              if ((s & 'h8000) != 0) s = s - 'h10000;
              acc = (acc + s) & DM;
            end
            default: push(0, 0, 0, 0, 0, "R13");
          endcase
        end
      endcase
    end
  endtask

  task automatic check(bit ok, string rq, string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s", rq, what);
    end
  endtask

  task automatic run_prog();
    mmem = dmem;
    run_model();
    q_rq[0] = "R1";
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    #1;
    check(halted_o == 1'b0 && mem_we_o == 1'b0, "R1",
          $sformatf("reset: halted %b we %b expected 0 0", halted_o, mem_we_o));
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < q_ca.size(); i++) begin
      #1;
      check((!q_ca[i] || int'(mem_addr_o) == q_ad[i]) && mem_we_o == q_we[i] &&
            (!q_we[i] || int'(mem_wdata_o) == q_wd[i]) && halted_o == q_h[i], q_rq[i],
            $sformatf("cycle %0d: addr %h/%h we %b/%b wdata %h/%h halted %b/%b (actual/expected)",
                      i, mem_addr_o, q_ad[i], mem_we_o, q_we[i], mem_wdata_o, q_wd[i],
                      halted_o, q_h[i]));
      @(negedge clk_i);
    end
    foreach (mmem[k])
      check(drd(k) == mmem[k], "R3",
            $sformatf("mem[%h] = %h expected %h", k, drd(k), mmem[k]));
    foreach (dmem[k])
      check(dmem[k] == mrd(k), "R13",
            $sformatf("mem[%h] = %h expected %h", k, dmem[k], mrd(k)));
  endtask

  initial begin
    // program A: data ops, rotates, immediates, register moves, halt
    dmem.delete();
    dmem['h200] = 'hFFFFFF; dmem['h201] = 'h0F0F0F;
    dmem['h202] = 'h300000; dmem['h203] = 'h555555;
    dmem[0]  = ins(2, 'h100);       // R1 acc zero after reset
    dmem[1]  = ins(0, 'hABCDE);     // R3
    dmem[2]  = ins(2, 'h101);
    dmem[3]  = ins(3, 'h200);       // R4 add wraps
    dmem[4]  = ins(2, 'h102);
    dmem[5]  = ins(4, 'h201);
    dmem[6]  = ins(5, 'h202);
    dmem[7]  = ins(6, 'h203);
    dmem[8]  = ins(2, 'h103);
    dmem[9]  = ins(7, 'h103);       // R5 equal
    dmem[10] = ins(2, 'h104);
    dmem[11] = ins(7, 'h201);       // R5 not equal
    dmem[12] = ins(2, 'h105);
    dmem[13] = ext('hF1, 0);        // R10 invert
    dmem[14] = ins(0, 1);
    dmem[15] = ext('hF2, 0);        // R10 wrap bit0 -> bit23
    dmem[16] = ins(2, 'h106);
    dmem[17] = ext('hF2, 0);
    dmem[18] = ext('hFA, 'hFFFE);   // R12 negative
    dmem[19] = ext('hFA, 'h7FFF);   // R12 positive
    dmem[20] = ins(2, 'h107);
    dmem[21] = ext('hF1, 0);
    dmem[22] = ext('hF7, 0);        // R11
    dmem[23] = ext('hF9, 0);
    dmem[24] = ext('hF5, 0);
    dmem[25] = ins(0, 'h12345);
    dmem[26] = ext('hF6, 0);
    dmem[27] = ins(2, 'h108);
    dmem[28] = ins(0, 0);
    dmem[29] = ext('hF8, 0);
    dmem[30] = ins(2, 'h109);
    dmem[31] = ins(0, 0);
    dmem[32] = ext('hF4, 0);
    dmem[33] = ins(2, 'h10A);
    dmem[34] = ext('hFB, 0);        // R13 undefined code
    dmem[35] = ext('hFE, 'h1234);
    dmem[36] = ins(2, 'h10B);
    dmem[37] = ext('hF0, 0);        // R13 halt
    dmem[38] = ins(2, 'h10C);
    run_prog();

    // program B: branches, call/return, indirect and stack-relative
    dmem.delete();
    dmem['h40]  = 'hF00160;         // R8 junk upper bits
    dmem['h41]  = 'hA00170;
    dmem['h160] = 'h777777;
    dmem['h10]  = 'h123456;         // R9 wrapped target
    dmem[0]  = ext('hF1, 0);
    dmem[1]  = ins(9, 4);           // R6 taken
    dmem[2]  = ins(2, 'h150);
    dmem[3]  = ext('hF0, 0);
    dmem[4]  = ins(0, 5);
    dmem[5]  = ins(9, 'h20);        // R6 not taken
    dmem[6]  = ins(12, 'h30);       // R7 call
    dmem[7]  = ins(2, 'h151);
    dmem[8]  = ins(10, 'h40);       // R8 indirect load
    dmem[9]  = ins(2, 'h152);
    dmem[10] = ins(11, 'h41);       // R8 indirect store
    dmem[11] = ins(0, 'hFFFF0);
    dmem[12] = ext('hF7, 0);
    dmem[13] = ins(13, 'h20);       // R9 wraps to 0x10
    dmem[14] = ins(14, 'h21);       // R9 wraps to 0x11
    dmem[15] = ins(8, 'h50);        // R6 jump
    dmem['h30] = ext('hFA, 9);
    dmem['h31] = ext('hF3, 0);      // R7 return
    dmem['h50] = ext('hF4, 0);
    dmem['h51] = ins(2, 'h153);
    dmem['h52] = ext('hF0, 0);
    run_prog();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule